// File: doc/BRIEF.md
# Retire-Gated Store Buffer with Fence Drain

This block sits between a core's execute stage and the write port of a level-one data cache. When a store executes, the only thing that happens is that its word address and data are written into a small in-order queue. Each entry starts out speculative. A retire pulse marks the oldest still-speculative entry as architecturally committed. Only committed entries are offered to the cache, oldest first, and the queue is back-pressured by the cache's write grant.

After a misprediction, a flush pulse throws away every entry that has not retired. Entries that have already retired stay in the queue and still drain to the cache. Loads look into the queue and take their data from the youngest entry with the same word address. If no entry matches, the load goes to the cache.

There are two kinds of fence. A full fence holds back every later load until the queue is completely empty. A load-serialising fence does not touch the queue, so later loads still proceed and may bypass older buffered stores.

Top module: `store_drain_buffer`

## Requirements
- R1: After reset the buffer is empty: `sb_empty`=1, `sb_full`=0, `st_ready`=1, `cw_valid`=0 and `fence_busy`=0.
- R2: A store is accepted on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` is the inverse of `sb_full`. Once DEPTH (default 8) entries are held, `sb_full`=1, and any store offered in that state is dropped.
- R3: An entry that has not retired is never presented on the cache write port.
- R4: Each cycle with `retire` high marks the oldest unretired entry present at the start of that cycle as retired. Retired entries are presented on `cw_addr`/`cw_data` oldest first, at most one per cycle. An entry leaves only on a cycle with `cw_grant` high, and while it is not granted its address and data hold steady.
- R5: A `flush` cycle discards every unretired entry and keeps every retired one. A store or retire offered in the same cycle as `flush` is ignored.
- R6: While `ld_valid` is high, `ld_fwd_hit` is 1 and `ld_fwd_data` carries the data of the youngest held entry whose address equals `ld_addr`. If no held entry matches, `ld_fwd_hit` is 0.
- R7: A fence request with `fence_kind`=1 (full) on a non-empty buffer raises `fence_busy` in the request cycle. `fence_busy` stays high until the buffer is empty, and `ld_grant` stays low while `fence_busy` is high.
- R8: A fence request with `fence_kind`=0 (load-serialising) leaves `fence_busy` low. Loads are still granted and still forward from older buffered stores.
- R9: A full fence requested while the buffer is empty does not raise `fence_busy`, and a load in that cycle is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Executed store offered |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Space available for a store |
| retire | input | 1 | Oldest unretired store has retired |
| flush | input | 1 | Discard all unretired stores |
| cw_valid | output | 1 | Retired entry offered to the cache |
| cw_addr | output | AW | Cache write word address |
| cw_data | output | DW | Cache write data |
| cw_grant | input | 1 | Cache accepts the offered write |
| fence_req | input | 1 | Fence instruction issued |
| fence_kind | input | 1 | 1 = full drain fence, 0 = load-serialising fence |
| fence_busy | output | 1 | Full fence waiting for the buffer to drain |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_grant | output | 1 | Load may proceed |
| ld_fwd_hit | output | 1 | Load data comes from the buffer |
| ld_fwd_data | output | DW | Forwarded load data |
| sb_full | output | 1 | All entries held |
| sb_empty | output | 1 | No entries held |

## Verification
The assertions rely on a few input rules. `retire` is only pulsed for stores that are really in the queue. The cache never withdraws a grant it has given within the same cycle. A full fence is eventually followed by enough retires or a flush to let the queue drain. The directed tasks honour these rules: they pulse `retire` only after the matching stores have been accepted, and they end every scenario by draining or flushing the queue back to empty before the next one starts. They drive `cw_grant` low on purpose to show that the write port holds, and raise it only to drain.

// File: rtl/sdb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the store drain buffer.
// Assumes: fence_kind is a single bit driven by the issue stage.
package sdb_pkg;
    typedef enum logic {
        FENCE_LOADSER = 1'b0,
        FENCE_DRAIN   = 1'b1
    } fence_kind_e;
endpackage

// File: rtl/sdb_queue.sv
`timescale 1ns/1ps
// Circular in-order store queue with a retired-prefix counter.
// The oldest ret_cnt entries are retired; only those are offered to the cache.
// Assumes: DEPTH is a power of two; retire is pulsed only for held stores.
module sdb_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          retire,
    input  logic          flush,
    input  logic          cw_grant,
    output logic          cw_valid,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    output logic [PW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] addr_q [DEPTH],
    output logic [DW-1:0] data_q [DEPTH]
);
    logic [PW-1:0] tail;
    logic [CW-1:0] ret_cnt;
    logic          push, pop, ret_inc;
    logic [PW-1:0] head_n, tail_n;
    logic [CW-1:0] count_n, ret_n;

    // Occupancy flags.
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Cache write port shows the oldest entry when it has retired.
    assign cw_valid = (ret_cnt != '0);
    assign cw_addr  = addr_q[head];
    assign cw_data  = data_q[head];

    // Per-cycle events; flush suppresses store and retire.
    always_comb begin
        pop     = cw_valid && cw_grant;
        push    = st_valid && !full && !flush;
        ret_inc = retire && !flush && (ret_cnt < count);
    end

    // Next-state pointers and counters.
    always_comb begin
        head_n = head + PW'(pop);
        ret_n  = ret_cnt + CW'(ret_inc) - CW'(pop);
        if (flush) begin
            tail_n  = head + PW'(ret_cnt);
            count_n = ret_cnt - CW'(pop);
        end else begin
            tail_n  = tail + PW'(push);
            count_n = count + CW'(push) - CW'(pop);
        end
    end

    // Pointer and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            count   <= '0;
            ret_cnt <= '0;
        end else begin
            head    <= head_n;
            tail    <= tail_n;
            count   <= count_n;
            ret_cnt <= ret_n;
        end
    end

    // Entry storage, written at the tail on an accepted store.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail] <= st_addr;
            data_q[tail] <= st_data;
        end
    end

    AST_RET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt <= count);  // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid && !cw_grant |=> cw_valid && $stable(cw_addr) && $stable(cw_data));  // R4
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !full && !flush |=> !empty);  // R2
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !cw_valid |=> empty);  // R5
endmodule

// File: rtl/sdb_fwd.sv
`timescale 1ns/1ps
// Store-to-load forwarding search over held entries.
// Scans from oldest to youngest so the youngest match wins.
// Assumes: count never exceeds DEPTH.
module sdb_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] addr_q [DEPTH],
    input  logic [DW-1:0] data_q [DEPTH],
    output logic          hit,
    output logic [DW-1:0] data
);
    // Age-ordered match; later (younger) matches overwrite earlier ones.
    always_comb begin
        logic [PW-1:0] idx;
        hit  = 1'b0;
        data = '0;
        for (int age = 0; age < DEPTH; age++) begin
            idx = head + PW'(age);
            if (ld_valid && (CW'(age) < count) && (addr_q[idx] == ld_addr)) begin
                hit  = 1'b1;
                data = data_q[idx];
            end
        end
    end
endmodule

// File: rtl/sdb_fence.sv
`timescale 1ns/1ps
// Fence tracker: a full fence holds later loads until the buffer is empty;
// a load-serialising fence leaves loads free.
// Assumes: empty reflects the registered occupancy of this cycle.
module sdb_fence
    import sdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic fence_kind,
    input  logic empty,
    input  logic ld_valid,
    output logic busy,
    output logic ld_grant
);
    logic pend_q;
    logic drain_req;

    // Only the full kind asks for a drain.
    assign drain_req = fence_req && (fence_kind_e'(fence_kind) == FENCE_DRAIN);

    // Busy from the request cycle until the buffer reads empty.
    assign busy     = (pend_q || drain_req) && !empty;
    assign ld_grant = ld_valid && !busy;

    // Remember an outstanding drain across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= busy;
    end

    AST_BUSY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !empty);  // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy || empty);  // R7
    AST_LOADSER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req && !fence_kind && !pend_q |-> !busy);  // R8
endmodule

// File: rtl/store_drain_buffer.sv
`timescale 1ns/1ps
// Top of the retire-gated store buffer: queue, forwarding search and
// fence tracker. Cache write port is valid/grant; loads see forwarded data.
// Assumes: synchronous active-low reset; word addressing.
module store_drain_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          retire,
    input  logic          flush,
    output logic          cw_valid,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    input  logic          cw_grant,
    input  logic          fence_req,
    input  logic          fence_kind,
    output logic          fence_busy,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_grant,
    output logic          ld_fwd_hit,
    output logic [DW-1:0] ld_fwd_data,
    output logic          sb_full,
    output logic          sb_empty
);
    logic [PW-1:0] head;
    logic [CW-1:0] count;
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];

    // Store acceptance follows free space.
    assign st_ready = !sb_full;

    sdb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .retire(retire), .flush(flush), .cw_grant(cw_grant),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data),
        .head(head), .count(count), .full(sb_full), .empty(sb_empty),
        .addr_q(addr_q), .data_q(data_q)
    );

    sdb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .head(head), .count(count), .addr_q(addr_q), .data_q(data_q),
        .hit(ld_fwd_hit), .data(ld_fwd_data)
    );

    sdb_fence u_fence (
        .clk(clk), .rst_n(rst_n),
        .fence_req(fence_req), .fence_kind(fence_kind), .empty(sb_empty),
        .ld_valid(ld_valid), .busy(fence_busy), .ld_grant(ld_grant)
    );

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        sb_full && !cw_grant && !flush |=> sb_full);  // R2
    AST_FENCE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && fence_busy |-> !ld_grant);  // R7
endmodule

// File: tb/store_drain_buffer_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module store_drain_buffer_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic st_valid, retire, flush, cw_grant, fence_req, fence_kind, ld_valid;
    logic [AW-1:0] st_addr, ld_addr;
    logic [DW-1:0] st_data;
    logic st_ready, cw_valid, fence_busy, ld_grant, ld_fwd_hit, sb_full, sb_empty;
    logic [AW-1:0] cw_addr;
    logic [DW-1:0] cw_data, ld_fwd_data;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    store_drain_buffer uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .retire(retire), .flush(flush),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data),
        .cw_grant(cw_grant), .fence_req(fence_req), .fence_kind(fence_kind),
        .fence_busy(fence_busy), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_grant(ld_grant), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data),
        .sb_full(sb_full), .sb_empty(sb_empty)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance to the next sampling point (after negedge).
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic idle_inputs();
        st_valid = 0; retire = 0; flush = 0; cw_grant = 0;
        fence_req = 0; fence_kind = 0; ld_valid = 0;
        st_addr = '0; st_data = '0; ld_addr = '0;
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1; st_addr = a; st_data = d;
        step();
        st_valid = 0;
    endtask

    task automatic drain_all();
        cw_grant = 1; retire = 1;
        for (int i = 0; i < 40 && !sb_empty; i++) step();
        cw_grant = 0; retire = 0;
    endtask

    task automatic t_reset();
        chk("R1", "empty", sb_empty, 1);
        chk("R1", "full", sb_full, 0);
        chk("R1", "st_ready", st_ready, 1);
        chk("R1", "cw_valid", cw_valid, 0);
        chk("R1", "fence_busy", fence_busy, 0);
    endtask

    task automatic t_commit_order();
        push(32'hA1, 32'h11); push(32'hA2, 32'h22); push(32'hA3, 32'h33);
        chk("R3", "cw_valid before retire", cw_valid, 0);
        retire = 1; step(); retire = 0;
        chk("R4", "cw_valid after one retire", cw_valid, 1);
        chk("R4", "oldest addr", cw_addr, 32'hA1);
        step();
        chk("R4", "held addr no grant", cw_addr, 32'hA1);
        chk("R4", "held data no grant", cw_data, 32'h11);
        retire = 1; step(); step(); retire = 0;
        cw_grant = 1;
        chk("R4", "commit 1 addr", cw_addr, 32'hA1); step();
        chk("R4", "commit 2 addr", cw_addr, 32'hA2); step();
        chk("R4", "commit 3 addr", cw_addr, 32'hA3);
        chk("R4", "commit 3 data", cw_data, 32'h33); step();
        cw_grant = 0;
        chk("R4", "empty after commits", sb_empty, 1);
    endtask

    task automatic t_flush();
        push(32'hB1, 32'h1); push(32'hB2, 32'h2); push(32'hB3, 32'h3);
        retire = 1; step(); retire = 0;
        flush = 1; retire = 1; st_valid = 1; st_addr = 32'hBF; st_data = 32'hF;
        step();
        flush = 0; retire = 0; st_valid = 0;
        chk("R5", "retired entry kept", cw_valid, 1);
        chk("R5", "retired entry addr", cw_addr, 32'hB1);
        ld_valid = 1; ld_addr = 32'hBF; #0.1;
        chk("R5", "store in flush cycle dropped", ld_fwd_hit, 0);
        ld_addr = 32'hB2; #0.1;
        chk("R5", "unretired entry gone", ld_fwd_hit, 0);
        ld_valid = 0;
        cw_grant = 1; step(); cw_grant = 0;
        chk("R5", "empty after one commit", sb_empty, 1);
    endtask

    task automatic t_forward();
        push(32'h10, 32'h1); push(32'h20, 32'h2); push(32'h10, 32'h3);
        ld_valid = 1; ld_addr = 32'h10; #0.1;
        chk("R6", "youngest hit", ld_fwd_hit, 1);
        chk("R6", "youngest data", ld_fwd_data, 32'h3);
        ld_addr = 32'h20; #0.1;
        chk("R6", "single match data", ld_fwd_data, 32'h2);
        ld_addr = 32'h30; #0.1;
        chk("R6", "no match", ld_fwd_hit, 0);
        ld_valid = 0;
        flush = 1; step(); flush = 0;
        chk("R5", "flush empties unretired", sb_empty, 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) push(32'h100 + i, 32'h50 + i);
        chk("R2", "full after 8", sb_full, 1);
        chk("R2", "st_ready low when full", st_ready, 0);
        push(32'h199, 32'h99);
        ld_valid = 1; ld_addr = 32'h199; #0.1;
        chk("R2", "store on full dropped", ld_fwd_hit, 0);
        ld_addr = 32'h107; #0.1;
        chk("R2", "last accepted entry held", ld_fwd_data, 32'h57);
        ld_valid = 0;
        flush = 1; step(); flush = 0;
        chk("R2", "empty after flush", sb_empty, 1);
    endtask

    task automatic t_full_fence();
        int bad = 0;
        push(32'hC1, 32'h1); push(32'hC2, 32'h2);
        fence_req = 1; fence_kind = 1; ld_valid = 1; ld_addr = 32'hC1; #0.1;
        chk("R7", "busy in request cycle", fence_busy, 1);
        chk("R7", "load blocked", ld_grant, 0);
        step(); fence_req = 0;
        retire = 1; cw_grant = 1;
        for (int i = 0; i < 20 && !sb_empty; i++) begin
            if (!fence_busy || ld_grant) bad++;
            step();
        end
        retire = 0; cw_grant = 0;
        chk("R7", "busy held while non-empty", bad, 0);
        chk("R7", "empty reached", sb_empty, 1);
        chk("R7", "busy released", fence_busy, 0);
        chk("R7", "load granted after drain", ld_grant, 1);
        ld_valid = 0;
    endtask

    task automatic t_light_fence();
        push(32'h40, 32'h7);
        fence_req = 1; fence_kind = 0; ld_valid = 1; ld_addr = 32'h40; #0.1;
        chk("R8", "no busy for load fence", fence_busy, 0);
        chk("R8", "load granted", ld_grant, 1);
        chk("R8", "forward past fence", ld_fwd_data, 32'h7);
        step();
        chk("R8", "still no busy next cycle", fence_busy, 0);
        fence_req = 0; ld_valid = 0;
        drain_all();
        fence_req = 1; fence_kind = 1; ld_valid = 1; #0.1;
        chk("R9", "full fence on empty not busy", fence_busy, 0);
        chk("R9", "load granted on empty", ld_grant, 1);
        step();
        fence_req = 0; ld_valid = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_commit_order();
        t_flush();
        t_forward();
        t_full();
        t_full_fence();
        t_light_fence();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule